// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is the integer arithmetic and logic stage of a processor datapath. It is purely combinational. It takes two operands, a four-bit operation code and the current carry flag, and it returns a result together with the negative, zero, carry and overflow condition flags. It also returns a result write enable and a per-flag write mask. An external status register and register file use these enables to decide what to store.

Every add-type operation uses the same adder: add, subtract, negate and compare. A front-end selects the adder's two inputs, optionally inverts the second one, and picks the carry-in, so the block contains no dedicated subtractor. The logical operations, single-step shifts and rotates through carry are handled by a separate unit. An opcode outside the supported set produces a zero result, disables every write and raises an illegal-operation output.

Top module: `flag_alu`

## Requirements
- R1: Opcode 0 (add) gives result = A + B modulo 2^W. C is the carry out of the top bit, result write is 1 and the flag mask is 4'b1111. The flag and mask vectors are ordered {N,Z,C,V}, with N at bit 3.
- R2: Opcode 1 (subtract) gives result = A + ~B + 1 modulo 2^W. C is the adder carry out, so C=1 means no borrow. Result write is 1 and the mask is 4'b1111.
- R3: For add, subtract, negate and compare, V is 1 exactly when the two adder inputs have the same sign and the result has the other sign. For subtract this means A and B differ in sign and the result sign differs from A.
- R4: For every operation that writes N, N equals result bit W-1. For every operation that writes Z, Z is 1 exactly when all result bits are 0.
- R5: Opcode 2 (negate) gives result = ~A + 1, formed as 0 + ~A + 1. Negating the most negative value returns that value with V=1. C is 1 only when A is 0. The mask is 4'b1111.
- R6: Opcode 3 (compare) sets the flags of a subtract with mask 4'b1111. Opcode 8 (test) sets N and Z of A & B with mask 4'b1100. Both drive result write to 0 while still presenting the computed value on the result port.
- R7: Opcodes 4 (A&B), 5 (A|B), 6 (A^B) and 7 (~A) write the result with mask 4'b1100. Any flag whose mask bit is 0 reads 0.
- R8: Opcode 9 shifts left by one and fills with 0. Opcode 10 shifts right by one and fills with 0. Opcode 11 shifts right by one and copies the sign bit. For all three, C is the bit shifted out, the mask is 4'b1110 and result write is 1.
- R9: Opcode 12 rotates left through carry: carry_in enters bit 0 and the old bit W-1 becomes C. Opcode 13 rotates right through carry: carry_in enters bit W-1 and the old bit 0 becomes C. The mask is 4'b1110.
- R10: Opcodes 14 and 15 give result 0, result write 0, mask 4'b0000, flags 0 and illegal_op = 1. Every other opcode gives illegal_op = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| opcode | input | 4 | Operation select |
| carry_in | input | 1 | Current carry flag, used by the rotates |
| result | output | WIDTH | Computed value |
| res_we | output | 1 | Result should be written to the destination |
| flags | output | 4 | Flag values {N,Z,C,V} |
| flag_we | output | 4 | Per-flag write mask {N,Z,C,V} |
| illegal_op | output | 1 | Opcode is not supported |

## Verification
Every output of this block is due in the same cycle its inputs change, with no register in between. The driver applies one operation just after a rising clock edge and pushes the expected item into the scoreboard queue. The monitor pops that item at the next falling edge, half a period later, once the combinational paths have settled. Exactly one operation is in flight per cycle, so each popped item is always matched against the stimulus that produced it.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_BITS = 4;

    typedef enum logic [OP_BITS-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_NEG = 4'd2,
        OP_CMP = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_NOT = 4'd7,
        OP_TST = 4'd8,
        OP_SHL = 4'd9,
        OP_SHR = 4'd10,
        OP_SAR = 4'd11,
        OP_ROL = 4'd12,
        OP_ROR = 4'd13
    } alu_op_e;

    // Flag vector order used on every flag bus: {N,Z,C,V}
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef enum logic [1:0] {
        GRP_ARITH = 2'd0,
        GRP_BITOP = 2'd1,
        GRP_NONE  = 2'd2
    } grp_e;

    typedef struct packed {
        grp_e  grp;
        logic  x_zero;    // adder input X forced to zero
        logic  y_from_a;  // adder input Y taken from operand A
        logic  y_inv;     // invert adder input Y
        logic  cin;       // adder carry-in
        logic  res_we;
        nzcv_t fwe;
        logic  illegal;
    } alu_ctrl_t;

    localparam nzcv_t MASK_ALL  = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
    localparam nzcv_t MASK_NZ   = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
    localparam nzcv_t MASK_NZC  = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
    localparam nzcv_t MASK_NONE = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic alu_ctrl_t arith_ctrl(logic x_zero, logic y_from_a,
                                             logic y_inv, logic cin, logic we);
        alu_ctrl_t c;
        c.grp      = GRP_ARITH;
        c.x_zero   = x_zero;
        c.y_from_a = y_from_a;
        c.y_inv    = y_inv;
        c.cin      = cin;
        c.res_we   = we;
        c.fwe      = MASK_ALL;
        c.illegal  = 1'b0;
        return c;
    endfunction

    function automatic alu_ctrl_t bitop_ctrl(nzcv_t mask, logic we);
        alu_ctrl_t c;
        c.grp      = GRP_BITOP;
        c.x_zero   = 1'b0;
        c.y_from_a = 1'b0;
        c.y_inv    = 1'b0;
        c.cin      = 1'b0;
        c.res_we   = we;
        c.fwe      = mask;
        c.illegal  = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [OP_BITS-1:0] opcode,
    output alu_ctrl_t          ctrl
);
    always_comb begin
        ctrl         = bitop_ctrl(MASK_NONE, 1'b0);
        ctrl.grp     = GRP_NONE;
        ctrl.illegal = 1'b1;
        case (opcode)
            OP_ADD:  ctrl = arith_ctrl(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            OP_SUB:  ctrl = arith_ctrl(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
            OP_NEG:  ctrl = arith_ctrl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
            OP_CMP:  ctrl = arith_ctrl(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
            OP_AND,
            OP_OR,
            OP_XOR,
            OP_NOT:  ctrl = bitop_ctrl(MASK_NZ, 1'b1);
            OP_TST:  ctrl = bitop_ctrl(MASK_NZ, 1'b0);
            OP_SHL,
            OP_SHR,
            OP_SAR,
            OP_ROL,
            OP_ROR:  ctrl = bitop_ctrl(MASK_NZC, 1'b1);
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  alu_ctrl_t        ctrl,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             overflow
);
    localparam int LOW = WIDTH - 1;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic [WIDTH:0]   full;
    logic [LOW:0]     low_part;
    logic             carry_into_msb;

    always_comb begin
        add_x    = ctrl.x_zero ? '0 : op_a;
        add_y    = ctrl.y_from_a ? op_a : op_b;
        add_y    = ctrl.y_inv ? ~add_y : add_y;
        full     = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, ctrl.cin};
        low_part = {1'b0, add_x[LOW-1:0]} + {1'b0, add_y[LOW-1:0]}
                 + {{LOW{1'b0}}, ctrl.cin};
        carry_into_msb = low_part[LOW];
    end

    assign sum       = full[WIDTH-1:0];
    assign carry_out = full[WIDTH];
    assign overflow  = carry_out ^ carry_into_msb;
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic [OP_BITS-1:0] opcode,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   value,
    output logic               shift_c
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        value   = '0;
        shift_c = 1'b0;
        case (opcode)
            OP_AND, OP_TST: value = op_a & op_b;
            OP_OR:          value = op_a | op_b;
            OP_XOR:         value = op_a ^ op_b;
            OP_NOT:         value = ~op_a;
            OP_SHL: begin
                value   = {op_a[MSB-1:0], 1'b0};
                shift_c = op_a[MSB];
            end
            OP_SHR: begin
                value   = {1'b0, op_a[MSB:1]};
                shift_c = op_a[0];
            end
            OP_SAR: begin
                value   = {op_a[MSB], op_a[MSB:1]};
                shift_c = op_a[0];
            end
            OP_ROL: begin
                value   = {op_a[MSB-1:0], carry_in};
                shift_c = op_a[MSB];
            end
            OP_ROR: begin
                value   = {carry_in, op_a[MSB:1]};
                shift_c = op_a[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic [OP_BITS-1:0] opcode,
    input  logic               carry_in,
    output logic [WIDTH-1:0]   result,
    output logic               res_we,
    output logic [3:0]         flags,
    output logic [3:0]         flag_we,
    output logic               illegal_op
);
    localparam int MSB = WIDTH - 1;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] sum;
    logic             add_c;
    logic             add_v;
    logic [WIDTH-1:0] bit_val;
    logic             bit_c;
    nzcv_t            raw;
    nzcv_t            masked;

    alu_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    alu_adder #(.WIDTH(WIDTH)) u_add (
        .op_a      (op_a),
        .op_b      (op_b),
        .ctrl      (ctrl),
        .sum       (sum),
        .carry_out (add_c),
        .overflow  (add_v)
    );

    alu_bitops #(.WIDTH(WIDTH)) u_bit (
        .op_a     (op_a),
        .op_b     (op_b),
        .opcode   (opcode),
        .carry_in (carry_in),
        .value    (bit_val),
        .shift_c  (bit_c)
    );

    always_comb begin
        case (ctrl.grp)
            GRP_ARITH: result = sum;
            GRP_BITOP: result = bit_val;
            default:   result = '0;
        endcase
        raw.n  = result[MSB];
        raw.z  = (result == '0);
        raw.c  = (ctrl.grp == GRP_ARITH) ? add_c : bit_c;
        raw.v  = add_v;
        masked = raw & ctrl.fwe;
    end

    assign res_we     = ctrl.res_we;
    assign flags      = masked;
    assign flag_we    = ctrl.fwe;
    assign illegal_op = ctrl.illegal;

    // Checks relating the decoder, the adder and the output mux.
    always_comb begin
        // R3
        if (opcode == OP_ADD)
            add_ovf_chk: assert (flags[0] == ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
                else $error("add overflow rule broken");
        // R3
        if (opcode == OP_SUB || opcode == OP_CMP)
            sub_ovf_chk: assert (flags[0] == ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])))
                else $error("subtract overflow rule broken");
        // R6
        if (opcode == OP_CMP || opcode == OP_TST)
            no_write_chk: assert (!res_we && flag_we[3] && flag_we[2])
                else $error("compare or test wrote a result");
        // R7
        if (opcode inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_TST})
            logic_cv_chk: assert (flag_we[1:0] == 2'b00 && flags[1:0] == 2'b00)
                else $error("logical op touched C or V");
        // R10
        if (illegal_op)
            illegal_quiet_chk: assert (result == '0 && !res_we && flag_we == 4'b0000)
                else $error("illegal op not silenced");
        // R4
        if (flag_we[2])
            zero_flag_chk: assert (flags[2] == ~|result)
                else $error("Z does not match result");
    end
endmodule

// File: tb/flag_alu_tb_top.sv
module flag_alu_tb_top;
    localparam int W = 8;
    localparam time HALF = 4ns;

    typedef struct {
        logic [3:0]   op;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         cin;
        logic [W-1:0] res;
        logic         rwe;
        logic [3:0]   fl;
        logic [3:0]   fwe;
        logic         ill;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [3:0]   opcode = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         res_we;
    logic [3:0]   flags;
    logic [3:0]   flag_we;
    logic         illegal_op;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #(HALF) clk = ~clk;

    flag_alu #(.WIDTH(W)) dut_i (
        .op_a       (op_a),
        .op_b       (op_b),
        .opcode     (opcode),
        .carry_in   (carry_in),
        .result     (result),
        .res_we     (res_we),
        .flags      (flags),
        .flag_we    (flag_we),
        .illegal_op (illegal_op)
    );

    // Expected behaviour computed from the requirements.
    function automatic item_t model(logic [3:0] op, logic [W-1:0] a,
                                    logic [W-1:0] b, logic cin, string tag);
        item_t e;
        logic [W:0] wide;
        logic c = 1'b0;
        logic v = 1'b0;
        e.op = op; e.a = a; e.b = b; e.cin = cin; e.tag = tag;
        e.rwe = 1'b1; e.ill = 1'b0; e.res = '0;
        case (op)
            4'd0: begin
                wide = {1'b0, a} + {1'b0, b};
                e.res = wide[W-1:0]; c = wide[W];
                v = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]);
                e.fwe = 4'b1111;
            end
            4'd1, 4'd3: begin
                wide = {1'b0, a} + {1'b0, ~b} + 1;
                e.res = wide[W-1:0]; c = wide[W];
                v = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]);
                e.fwe = 4'b1111;
                e.rwe = (op == 4'd1);
            end
            4'd2: begin
                e.res = ~a + 1'b1;
                c = (a == '0);
                v = (a == {1'b1, {(W-1){1'b0}}});
                e.fwe = 4'b1111;
            end
            4'd4, 4'd8: begin e.res = a & b; e.fwe = 4'b1100; e.rwe = (op == 4'd4); end
            4'd5: begin e.res = a | b; e.fwe = 4'b1100; end
            4'd6: begin e.res = a ^ b; e.fwe = 4'b1100; end
            4'd7: begin e.res = ~a; e.fwe = 4'b1100; end
            4'd9:  begin e.res = a << 1; c = a[W-1]; e.fwe = 4'b1110; end
            4'd10: begin e.res = a >> 1; c = a[0]; e.fwe = 4'b1110; end
            4'd11: begin e.res = {a[W-1], a[W-1:1]}; c = a[0]; e.fwe = 4'b1110; end
            4'd12: begin e.res = {a[W-2:0], cin}; c = a[W-1]; e.fwe = 4'b1110; end
            4'd13: begin e.res = {cin, a[W-1:1]}; c = a[0]; e.fwe = 4'b1110; end
            default: begin e.fwe = 4'b0000; e.rwe = 1'b0; e.ill = 1'b1; end
        endcase
        e.fl = {e.res[W-1], e.res == '0, c, v} & e.fwe;
        return e;
    endfunction

    task automatic drive(logic [3:0] op, logic [W-1:0] a, logic [W-1:0] b,
                         logic cin, string tag);
        @(posedge clk);
        op_a = a; op_b = b; opcode = op; carry_in = cin;
        sb_q.push_back(model(op, a, b, cin, tag));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor: one expected item per cycle, compared half a period later.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t e;
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res || res_we !== e.rwe || flags !== e.fl ||
                flag_we !== e.fwe || illegal_op !== e.ill) begin
                failures++;
                $display("FAIL %s op=%0d a=%h b=%h cin=%b: got res=%h we=%b fl=%b fwe=%b ill=%b, expected res=%h we=%b fl=%b fwe=%b ill=%b",
                         e.tag, e.op, e.a, e.b, e.cin, result, res_we, flags, flag_we,
                         illegal_op, e.res, e.rwe, e.fl, e.fwe, e.ill);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state after reset: add of zeros gives Z only (R4)
        drive(4'd0, 8'h00, 8'h00, 1'b0, "R4 idle");
        // R1 add
        drive(4'd0, 8'h03, 8'h04, 1'b0, "R1 add small");
        drive(4'd0, 8'hFF, 8'h01, 1'b0, "R1 add carry");
        drive(4'd0, 8'h7F, 8'h01, 1'b0, "R3 add positive overflow");
        drive(4'd0, 8'h80, 8'h80, 1'b0, "R3 add negative overflow");
        // R2 subtract
        drive(4'd1, 8'h02, 8'h07, 1'b0, "R2 sub borrow");
        drive(4'd1, 8'hFB, 8'h02, 1'b0, "R2 sub no borrow");
        drive(4'd1, 8'h80, 8'h01, 1'b0, "R3 sub overflow");
        drive(4'd1, 8'h05, 8'h05, 1'b0, "R4 sub zero");
        // R5 negate
        drive(4'd2, 8'h12, 8'h00, 1'b0, "R5 neg");
        drive(4'd2, 8'h80, 8'h00, 1'b0, "R5 neg most negative");
        drive(4'd2, 8'h00, 8'h00, 1'b0, "R5 neg zero");
        // R6 compare and test
        drive(4'd3, 8'h05, 8'h05, 1'b0, "R6 cmp equal");
        drive(4'd3, 8'h03, 8'h09, 1'b1, "R6 cmp less");
        drive(4'd8, 8'hF0, 8'h0F, 1'b0, "R6 test zero");
        drive(4'd8, 8'hF0, 8'h80, 1'b0, "R6 test negative");
        // R7 logical
        drive(4'd4, 8'hCC, 8'hAA, 1'b1, "R7 and");
        drive(4'd5, 8'h0C, 8'hA0, 1'b1, "R7 or");
        drive(4'd6, 8'hFF, 8'hFF, 1'b1, "R7 xor");
        drive(4'd7, 8'h0F, 8'h00, 1'b1, "R7 not");
        // R8 shifts
        drive(4'd9, 8'h81, 8'h00, 1'b0, "R8 shl");
        drive(4'd10, 8'h01, 8'h00, 1'b1, "R8 shr");
        drive(4'd11, 8'h80, 8'h00, 1'b1, "R8 sar negative");
        drive(4'd11, 8'h43, 8'h00, 1'b0, "R8 sar positive");
        // R9 rotates through carry
        drive(4'd12, 8'h80, 8'h00, 1'b0, "R9 rol out");
        drive(4'd12, 8'h01, 8'h00, 1'b1, "R9 rol in");
        drive(4'd13, 8'h01, 8'h00, 1'b1, "R9 ror");
        drive(4'd13, 8'hA4, 8'h00, 1'b0, "R9 ror no carry");
        // R10 illegal
        drive(4'd14, 8'hFF, 8'h01, 1'b1, "R10 illegal 14");
        drive(4'd15, 8'h12, 8'h34, 1'b0, "R10 illegal 15");
        // A few sweeps of add and subtract (R1, R2)
        for (int i = 0; i < 16; i++) begin
            drive(4'(i % 2), 8'(i * 37 + 5), 8'(i * 91 + 200), 1'b0, "R1 R2 sweep");
        end
        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog (all requirements): got timeout, expected completion");
            finish_run();
        end
    end
endmodule